// File: doc/BRIEF.md
# Banked UART Extended Register Window

This block is a byte-wide, memory-mapped register front end placed ahead of a conventional 16550-class UART core. Every bus read or write is decoded by offset. Depending on the current access mode and on two enable bits, the access is served by a small bank of local extended registers or is passed straight to the core's own register port. The core port carries the same offset, data and strobe, and it returns read data in the same cycle.

The access mode is learned only by watching writes to the line-control offset. The bus sees one of three views: operational, configuration A or configuration B. Configuration B overlays the enhanced-feature register and four flow-control characters on offsets that normally belong to the core. The trigger-level pair overlays two of those offsets whenever the enhanced-feature enable and a locally cached modem-control bit are both set. Two bits of the modem-control register are kept in this block and merged into the value the core returns. A system-control write can soft-reset the local bank.

Top module: `uart_xreg_window`

## Requirements
- R1: A write to offset 0x0C is always forwarded to the core. It also sets the access mode: data 0xBF selects configuration B; any other value with bit 7 set selects configuration A; any remaining value selects operational mode.
- R2: Offset 0x08 reads and writes the local enhanced-feature register (8 bits) in configuration B. In operational mode and configuration A it is forwarded to the core.
- R3: In configuration B, offsets 0x10 and 0x14 access local 8-bit characters XON-1 and XON-2. Offsets 0x18 and 0x1C access XOFF-1 and XOFF-2, unless R4 applies. None of these accesses is forwarded.
- R4: When enhanced-feature bit 4 and cached modem-control bit 6 are both 1, offsets 0x18 and 0x1C access the local 8-bit trigger-control and trigger-level registers. This holds in every mode, takes priority over R3, and the access is not forwarded.
- R5: Outside configuration B, a write to 0x10 is forwarded to the core. When enhanced-feature bit 4 is 1, the same write also stores its bits 6:5 locally. A read of 0x10 outside configuration B returns the core data ORed with the stored bits. Outside configuration B, 0x14 is forwarded, and so are 0x18 and 0x1C when R4 does not apply.
- R6: After reset the block is in operational mode. Trigger-control reads 0x0F, 0x38 reads 0x40, 0x5C reads 0x3F and 0x60 reads 0x69. Every other local register reads 0.
- R7: Offsets 0x38 and 0x3C accept writes only in operational mode. 0x38 keeps bits 7:6 and 0x3C keeps all 8 bits. In either configuration mode both offsets read 0 and writes to them are ignored.
- R8: Offset 0x54 keeps written bits under mask 0x1D. A write with bit 1 set soft-resets the access mode and every local register to its R6 value, including 0x54 itself. It leaves 0x20, 0x24 and 0x40 unchanged.
- R9: Write masks are 0x7F at 0x20, 0xFF at 0x24, 0x7F at 0x5C and 0x01 at 0x4C. The registers at 0x40, 0x48 and 0x60 keep all 8 bits. All of these read back their stored value in any mode.
- R10: Offset 0x50 reads 0x30 and offset 0x58 reads 0x01. Offsets 0x28, 0x2C, 0x30, 0x34 and 0x44 read 0. Writes to all of these are ignored.
- R11: Offsets 0x00 and 0x04 are always forwarded. A forwarded access presents the bus offset and write data on the core port, raises the matching core strobe in the same cycle, and returns the core's read data. The core strobes are low for every access that is not forwarded.
- R12: An access to an offset that is not a multiple of 4, or that lies above 0x60, reads 0 and changes no state. It raises the error output for exactly the following cycle. Every mapped access leaves the error output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| bus_err | output | 1 | One-cycle pulse following an unmapped access |
| core_addr | output | 8 | Offset forwarded to the core |
| core_wdata | output | 8 | Write data forwarded to the core |
| core_wr | output | 1 | Forwarded write strobe |
| core_rd | output | 1 | Forwarded read strobe |
| core_rdata | input | 8 | Core read data, combinational |

## Verification
On every cycle, the assertions check these properties:
- the line-control write always reaches the core, and data 0xBF puts the block into configuration B;
- the enhanced-feature and trigger-level overlays keep the core strobes low;
- the extended offsets read 0 in the configuration modes, and the constant offsets hold their values;
- a soft reset returns the block to operational mode;
- the error output follows unmapped offsets and nothing else.

Only the bench scenarios can show the following:
- the exact masks and reset values;
- that the modem-control bits are captured only under the enable bit;
- which registers survive a soft reset;
- that ignored writes to read-only and unmapped offsets really leave state untouched.

The bench shows these by reading the registers back against its own model after long random mixes of mode changes.

// File: rtl/xwin_pkg.sv
// Package: shared types and constants for the banked UART register window.
// Assumes byte-wide registers on 4-byte-aligned offsets.
package xwin_pkg;
    localparam int AW = 8;   // bus offset width
    localparam int DW = 8;   // register data width

    // Access view selected by writes to the line-control offset
    typedef enum logic [1:0] {
        M_OPER = 2'd0,
        M_CFGA = 2'd1,
        M_CFGB = 2'd2
    } acc_mode_t;

    // Decoded destination of one bus access
    typedef enum logic [4:0] {
        T_FWD, T_FWD_LCR, T_FWD_MCR, T_EFR, T_XON1, T_XON2, T_XOFF1, T_XOFF2,
        T_TCR, T_TLR, T_MDR1, T_MDR2, T_RO0, T_BLR, T_ACR, T_SCR, T_EBLR,
        T_CLK, T_VER, T_SYSC, T_STAT, T_WAKE, T_CFPS, T_BAD
    } tgt_t;

    localparam logic [DW-1:0] CFGB_KEY  = 8'hBF;
    localparam logic [DW-1:0] VER_VAL   = 8'h30;
    localparam logic [DW-1:0] STAT_VAL  = 8'h01;
    localparam logic [DW-1:0] TCR_RST   = 8'h0F;
    localparam logic [DW-1:0] BLR_RST   = 8'h40;
    localparam logic [DW-1:0] WAKE_RST  = 8'h3F;
    localparam logic [DW-1:0] CFPS_RST  = 8'h69;
    localparam logic [DW-1:0] SYSC_MASK = 8'h1D;
    localparam logic [DW-1:0] MDR1_MASK = 8'h7F;
    localparam logic [DW-1:0] WAKE_MASK = 8'h7F;
    localparam logic [DW-1:0] BLR_MASK  = 8'hC0;
    localparam int            EFR_EN_BIT = 4;
    localparam int            SRST_BIT   = 1;
endpackage

// File: rtl/xwin_decode.sv
// Module: xwin_decode
// Maps a bus offset to a destination, given the current access mode and
// whether the trigger-level overlay is enabled. Purely combinational.
module xwin_decode
    import xwin_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  acc_mode_t     mode,
    input  logic          tt_en,
    output tgt_t          tgt
);
    logic cfgb;
    logic oper;
    assign cfgb = (mode == M_CFGB);
    assign oper = (mode == M_OPER);

    // Offset and mode decode into one destination
    always_comb begin
        tgt = T_BAD;
        case (addr)
            8'h00, 8'h04: tgt = T_FWD;
            8'h0C:        tgt = T_FWD_LCR;
            8'h08:        tgt = cfgb ? T_EFR  : T_FWD;
            8'h10:        tgt = cfgb ? T_XON1 : T_FWD_MCR;
            8'h14:        tgt = cfgb ? T_XON2 : T_FWD;
            8'h18:        tgt = tt_en ? T_TCR : (cfgb ? T_XOFF1 : T_FWD);
            8'h1C:        tgt = tt_en ? T_TLR : (cfgb ? T_XOFF2 : T_FWD);
            8'h20:        tgt = T_MDR1;
            8'h24:        tgt = T_MDR2;
            8'h28, 8'h2C, 8'h30, 8'h34, 8'h44: tgt = T_RO0;
            8'h38:        tgt = oper ? T_BLR : T_RO0;
            8'h3C:        tgt = oper ? T_ACR : T_RO0;
            8'h40:        tgt = T_SCR;
            8'h48:        tgt = T_EBLR;
            8'h4C:        tgt = T_CLK;
            8'h50:        tgt = T_VER;
            8'h54:        tgt = T_SYSC;
            8'h58:        tgt = T_STAT;
            8'h5C:        tgt = T_WAKE;
            8'h60:        tgt = T_CFPS;
            default:      tgt = T_BAD;
        endcase
    end
endmodule

// File: rtl/xwin_mode.sv
// Module: xwin_mode
// Tracks the access mode from line-control writes; a soft reset returns
// it to operational. Assumes both events never coincide.
module xwin_mode
    import xwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lcr_wr,
    input  logic [DW-1:0] wdata,
    input  logic          soft_rst,
    output acc_mode_t     mode
);
    // Mode register update
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mode <= M_OPER;
        end else if (lcr_wr) begin
            if (wdata == CFGB_KEY)   mode <= M_CFGB;
            else if (wdata[DW-1])    mode <= M_CFGA;
            else                     mode <= M_OPER;
        end
    end
endmodule

// File: rtl/xwin_regs.sv
// Module: xwin_regs
// Local extended register bank and read-data mux. Writes apply their
// masks; a system-control write with the reset bit restores the bank.
// Assumes the destination is already decoded.
module xwin_regs
    import xwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  tgt_t          tgt,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] core_rdata,
    output logic [DW-1:0] rdata,
    output logic          tt_en,
    output logic          soft_rst
);
    logic [DW-1:0] efr_q, tcr_q, tlr_q, xon1_q, xon2_q, xoff1_q, xoff2_q;
    logic [DW-1:0] blr_q, acr_q, eblr_q, sysc_q, wake_q, cfps_q;
    logic [DW-1:0] mdr1_q, mdr2_q, scr_q;
    logic [1:0]    mcr_q;   // cached modem-control bits 6:5
    logic          clk_q;

    assign soft_rst = wr && (tgt == T_SYSC) && wdata[SRST_BIT];
    assign tt_en    = efr_q[EFR_EN_BIT] && mcr_q[1];

    // Soft-resettable bank
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            efr_q <= '0; tcr_q <= TCR_RST; tlr_q <= '0;
            xon1_q <= '0; xon2_q <= '0; xoff1_q <= '0; xoff2_q <= '0;
            blr_q <= BLR_RST; acr_q <= '0; eblr_q <= '0; sysc_q <= '0;
            wake_q <= WAKE_RST; cfps_q <= CFPS_RST; mcr_q <= '0; clk_q <= 1'b0;
        end else if (wr) begin
            case (tgt)
                T_EFR:     efr_q   <= wdata;
                T_TCR:     tcr_q   <= wdata;
                T_TLR:     tlr_q   <= wdata;
                T_XON1:    xon1_q  <= wdata;
                T_XON2:    xon2_q  <= wdata;
                T_XOFF1:   xoff1_q <= wdata;
                T_XOFF2:   xoff2_q <= wdata;
                T_BLR:     blr_q   <= wdata & BLR_MASK;
                T_ACR:     acr_q   <= wdata;
                T_EBLR:    eblr_q  <= wdata;
                T_SYSC:    sysc_q  <= wdata & SYSC_MASK;
                T_WAKE:    wake_q  <= wdata & WAKE_MASK;
                T_CFPS:    cfps_q  <= wdata;
                T_CLK:     clk_q   <= wdata[0];
                T_FWD_MCR: if (efr_q[EFR_EN_BIT]) mcr_q <= wdata[6:5];
                default:   ;
            endcase
        end
    end

    // Registers kept across a soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr1_q <= '0; mdr2_q <= '0; scr_q <= '0;
        end else if (wr) begin
            case (tgt)
                T_MDR1:  mdr1_q <= wdata & MDR1_MASK;
                T_MDR2:  mdr2_q <= wdata;
                T_SCR:   scr_q  <= wdata;
                default: ;
            endcase
        end
    end

    // Read data selection
    always_comb begin
        case (tgt)
            T_FWD, T_FWD_LCR: rdata = core_rdata;
            T_FWD_MCR: rdata = core_rdata | {1'b0, mcr_q, 5'b0};
            T_EFR:     rdata = efr_q;
            T_XON1:    rdata = xon1_q;
            T_XON2:    rdata = xon2_q;
            T_XOFF1:   rdata = xoff1_q;
            T_XOFF2:   rdata = xoff2_q;
            T_TCR:     rdata = tcr_q;
            T_TLR:     rdata = tlr_q;
            T_MDR1:    rdata = mdr1_q;
            T_MDR2:    rdata = mdr2_q;
            T_BLR:     rdata = blr_q;
            T_ACR:     rdata = acr_q;
            T_SCR:     rdata = scr_q;
            T_EBLR:    rdata = eblr_q;
            T_CLK:     rdata = {{(DW-1){1'b0}}, clk_q};
            T_VER:     rdata = VER_VAL;
            T_SYSC:    rdata = sysc_q;
            T_STAT:    rdata = STAT_VAL;
            T_WAKE:    rdata = wake_q;
            T_CFPS:    rdata = cfps_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_xreg_window.sv
// Module: uart_xreg_window
// Top level: decodes bus accesses, forwards core accesses with the same
// offset, data and strobe, serves local registers and flags unmapped
// offsets. Assumes single-cycle strobes and a combinational core read.
module uart_xreg_window
    import xwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    output logic [AW-1:0] core_addr,
    output logic [DW-1:0] core_wdata,
    output logic          core_wr,
    output logic          core_rd,
    input  logic [DW-1:0] core_rdata
);
    acc_mode_t mode_q;
    tgt_t      tgt;
    logic      tt_en;
    logic      soft_rst;
    logic      fwd;
    logic      err_q;

    xwin_decode u_dec (
        .addr(bus_addr), .mode(mode_q), .tt_en(tt_en), .tgt(tgt)
    );

    xwin_mode u_mode (
        .clk(clk), .rst_n(rst_n),
        .lcr_wr(bus_wr && (tgt == T_FWD_LCR)),
        .wdata(bus_wdata), .soft_rst(soft_rst), .mode(mode_q)
    );

    xwin_regs u_regs (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .wr(bus_wr),
        .wdata(bus_wdata), .core_rdata(core_rdata), .rdata(bus_rdata),
        .tt_en(tt_en), .soft_rst(soft_rst)
    );

    assign fwd        = (tgt == T_FWD) || (tgt == T_FWD_LCR) || (tgt == T_FWD_MCR);
    assign core_addr  = bus_addr;
    assign core_wdata = bus_wdata;
    assign core_wr    = bus_wr && fwd;
    assign core_rd    = bus_rd && fwd;
    assign bus_err    = err_q;

    // Error pulse for the cycle after an unmapped access
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (bus_wr || bus_rd) && (tgt == T_BAD);
    end
endmodule

// File: rtl/xwin_checker.sv
// Module: xwin_checker
// Cycle-level properties of the register window, bound to the top.
module xwin_checker
    import xwin_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_err,
    input logic          core_wr,
    input logic          core_rd,
    input acc_mode_t     mode,
    input logic          tt_en
);
    logic acc;
    assign acc = bus_wr || bus_rd;

    assert_lcr_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h0C) |-> core_wr);
    assert_mode_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h0C && bus_wdata == 8'hBF) |=> (mode == M_CFGB));
    assert_efr_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_addr == 8'h08 && mode == M_CFGB) |-> !(core_rd || core_wr));
    assert_tt_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (bus_addr == 8'h18 || bus_addr == 8'h1C) && tt_en) |-> !(core_rd || core_wr));
    assert_blr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 8'h38 || bus_addr == 8'h3C) && mode != M_OPER) |-> (bus_rdata == 8'h00));
    assert_soft_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h54 && bus_wdata[1]) |=> (mode == M_OPER));
    assert_ver_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h50) |-> (bus_rdata == 8'h30));
    assert_stat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h58) |-> (bus_rdata == 8'h01));
    assert_core_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |-> bus_wr);
    assert_core_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd |-> bus_rd);
    assert_bad_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (bus_addr[1:0] != 2'b00 || bus_addr > 8'h60)) |=> bus_err);
    assert_err_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !bus_err);
endmodule

bind uart_xreg_window xwin_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .core_wr(core_wr), .core_rd(core_rd), .mode(mode_q), .tt_en(tt_en)
);

// File: tb/uart_xreg_window_bench.sv
// Bench: directed corner cases and seeded random accesses, checked
// against a register model built from the requirements.
module uart_xreg_window_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata, core_addr, core_wdata, core_rdata;
    logic       bus_err, core_wr, core_rd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // Core stub: read data derived from the offset
    assign core_rdata = core_addr ^ 8'h81;

    uart_xreg_window u_uart_xreg_window (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_wr(core_wr),
        .core_rd(core_rd), .core_rdata(core_rdata)
    );

    // Model state
    int m_mode;  // 0 operational, 1 config A, 2 config B
    logic [7:0] efr, tcr, tlr, xon1, xon2, xoff1, xoff2, mcr, mdr1, mdr2;
    logic [7:0] blr, acr, scr, eblr, clks, sysc, wake, cfps;

    function automatic void model_reset(bit hard);
        m_mode = 0; efr = 0; tcr = 8'h0F; tlr = 0; xon1 = 0; xon2 = 0;
        xoff1 = 0; xoff2 = 0; mcr = 0; blr = 8'h40; acr = 0; eblr = 0;
        clks = 0; sysc = 0; wake = 8'h3F; cfps = 8'h69;
        if (hard) begin mdr1 = 0; mdr2 = 0; scr = 0; end
    endfunction

    function automatic bit tt();
        return efr[4] && mcr[6];
    endfunction

    function automatic bit exp_bad(logic [7:0] a);
        return (a[1:0] != 2'b00) || (a > 8'h60);
    endfunction

    function automatic bit exp_fwd(logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h0C: return 1;
            8'h08, 8'h10, 8'h14: return m_mode != 2;
            8'h18, 8'h1C:        return !tt() && m_mode != 2;
            default:             return 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(logic [7:0] a);
        if (exp_bad(a)) return 8'h00;
        if (a == 8'h10 && m_mode != 2) return (a ^ 8'h81) | mcr;
        if (exp_fwd(a)) return a ^ 8'h81;
        case (a)
            8'h08: return efr;
            8'h10: return xon1;
            8'h14: return xon2;
            8'h18: return tt() ? tcr : xoff1;
            8'h1C: return tt() ? tlr : xoff2;
            8'h20: return mdr1;
            8'h24: return mdr2;
            8'h38: return (m_mode == 0) ? blr : 8'h00;
            8'h3C: return (m_mode == 0) ? acr : 8'h00;
            8'h40: return scr;
            8'h48: return eblr;
            8'h4C: return clks;
            8'h50: return 8'h30;
            8'h54: return sysc;
            8'h58: return 8'h01;
            8'h5C: return wake;
            8'h60: return cfps;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_wr(logic [7:0] a, logic [7:0] d);
        if (exp_bad(a)) return;
        case (a)
            8'h0C: m_mode = (d == 8'hBF) ? 2 : (d[7] ? 1 : 0);
            8'h08: if (m_mode == 2) efr = d;
            8'h10: if (m_mode == 2) xon1 = d; else if (efr[4]) mcr = d & 8'h60;
            8'h14: if (m_mode == 2) xon2 = d;
            8'h18: if (tt()) tcr = d; else if (m_mode == 2) xoff1 = d;
            8'h1C: if (tt()) tlr = d; else if (m_mode == 2) xoff2 = d;
            8'h20: mdr1 = d & 8'h7F;
            8'h24: mdr2 = d;
            8'h38: if (m_mode == 0) blr = d & 8'hC0;
            8'h3C: if (m_mode == 0) acr = d;
            8'h40: scr = d;
            8'h48: eblr = d;
            8'h4C: clks = {7'b0, d[0]};
            8'h54: if (d[1]) model_reset(0); else sysc = d & 8'h1D;
            8'h5C: wake = d & 8'h7F;
            8'h60: cfps = d;
            default: ;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (exp_bad(a)) return "R12";
        case (a)
            8'h0C: return "R1";
            8'h08: return "R2";
            8'h10, 8'h14: return (m_mode == 2) ? "R3" : "R5";
            8'h18, 8'h1C: return tt() ? "R4" : ((m_mode == 2) ? "R3" : "R5");
            8'h38, 8'h3C: return "R7";
            8'h54: return "R8";
            8'h20, 8'h24, 8'h40, 8'h48, 8'h4C, 8'h5C, 8'h60: return "R9";
            8'h00, 8'h04: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        bit f;
        bit b;
        f = exp_fwd(a);
        b = exp_bad(a);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        check("R11", $sformatf("core_wr @%0h", a), {31'b0, core_wr}, {31'b0, f});
        if (f) check("R11", "core addr/data", {16'b0, core_addr, core_wdata}, {16'b0, a, d});
        model_wr(a, d);
        @(posedge clk); #1;
        bus_wr = 1'b0;
        check("R12", $sformatf("err after write @%0h", a), {31'b0, bus_err}, {31'b0, b});
    endtask

    task automatic do_read(logic [7:0] a, string tag = "");
        bit f;
        bit b;
        logic [7:0] e;
        string t;
        f = exp_fwd(a);
        b = exp_bad(a);
        e = exp_rd(a);
        t = (tag == "") ? tag_of(a) : tag;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(t, $sformatf("rdata @%0h", a), {24'b0, bus_rdata}, {24'b0, e});
        check("R11", $sformatf("core_rd @%0h", a), {31'b0, core_rd}, {31'b0, f});
        @(posedge clk); #1;
        bus_rd = 1'b0;
        check("R12", $sformatf("err after read @%0h", a), {31'b0, bus_err}, {31'b0, b});
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus
    initial begin
        logic [7:0] a, d;
        void'($urandom(32'h00C0FFEE));
        model_reset(1);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R12", "err after reset", {31'b0, bus_err}, 32'd0);

        // R6: reset values
        do_read(8'h38, "R6"); do_read(8'h5C, "R6"); do_read(8'h60, "R6");
        do_read(8'h3C, "R6"); do_read(8'h4C, "R6"); do_read(8'h54, "R6");
        do_read(8'h48, "R6"); do_read(8'h20, "R6"); do_read(8'h08, "R6");
        // MCR capture blocked while EFR bit 4 clear (R5)
        do_write(8'h10, 8'h60); do_read(8'h10, "R5");
        // Enter config B (R1), set EFR enable, check XON/XOFF (R3)
        do_write(8'h0C, 8'hBF); do_read(8'h08, "R2");
        do_write(8'h08, 8'h10); do_read(8'h08, "R2");
        do_write(8'h10, 8'hA1); do_write(8'h14, 8'hA2);
        do_write(8'h18, 8'hA3); do_write(8'h1C, 8'hA4);
        do_read(8'h10, "R3"); do_read(8'h14, "R3");
        do_read(8'h18, "R3"); do_read(8'h1C, "R3");
        do_read(8'h38, "R7"); do_write(8'h38, 8'hFF);
        // Config A: BLR hidden, EFR forwarded
        do_write(8'h0C, 8'h83); do_read(8'h08, "R2"); do_read(8'h3C, "R7");
        do_write(8'h3C, 8'h55);
        // Operational, capture MCR bit 6 -> TCR/TLR overlay (R4, R6)
        do_write(8'h0C, 8'h03); do_read(8'h38, "R7"); do_read(8'h3C, "R7");
        do_write(8'h10, 8'h7F); do_read(8'h10, "R5");
        do_read(8'h18, "R6"); do_read(8'h1C, "R4");
        do_write(8'h18, 8'h5A); do_write(8'h1C, 8'hC3);
        do_write(8'h0C, 8'hBF); do_read(8'h18, "R4"); do_read(8'h1C, "R4");
        do_write(8'h0C, 8'h00);
        // Masks (R9) and read-only offsets (R10)
        do_write(8'h20, 8'hFF); do_write(8'h24, 8'hFF); do_write(8'h5C, 8'hFF);
        do_write(8'h4C, 8'hFE); do_write(8'h40, 8'h9C);
        do_read(8'h20, "R9"); do_read(8'h24, "R9"); do_read(8'h5C, "R9");
        do_read(8'h4C, "R9"); do_read(8'h40, "R9");
        do_write(8'h50, 8'h00); do_read(8'h50, "R10");
        do_write(8'h58, 8'hFF); do_read(8'h58, "R10");
        do_write(8'h28, 8'hFF); do_read(8'h28, "R10"); do_read(8'h44, "R10");
        // System control mask and soft reset (R8)
        do_write(8'h54, 8'hFD); do_read(8'h54, "R8");
        do_write(8'h0C, 8'hBF);
        do_write(8'h54, 8'h02);
        do_read(8'h54, "R8"); do_read(8'h08, "R8"); do_read(8'h18, "R8");
        do_read(8'h20, "R8"); do_read(8'h40, "R8"); do_read(8'h5C, "R8");
        // Unmapped offsets (R12)
        do_write(8'h6C, 8'hFF); do_write(8'h5E, 8'hFF);
        do_read(8'h61, "R12"); do_read(8'hFC, "R12"); do_read(8'h5E, "R12");
        do_read(8'h5C, "R12"); do_read(8'h00, "R11"); do_read(8'h04, "R11");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 32);
            if (r < 25) a = 8'(r * 4);
            else        a = 8'($urandom);
            d = 8'($urandom);
            if (a == 8'h0C) begin
                case ($urandom % 4)
                    0: d = 8'hBF;
                    1: d = d | 8'h80;
                    2: d = d & 8'h7F;
                    default: ;
                endcase
            end
            if (a == 8'h54 && ($urandom % 8) != 0) d[1] = 1'b0;
            if ($urandom % 2) do_write(a, d);
            else              do_read(a);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule